// File: doc/BRIEF.md
# Registered-Carry Up/Down Counter Slice

This block is one slice of a synchronous counter. It is W bits wide, with W = 6 by default. A two-bit mode input selects one of four actions: load the count from a parallel data input, count up, count down, or hold. The two counting modes step only when both of these are low:

- the active-low carry-in, and
- a one-clock-delayed copy of the active-low look-ahead carry-in.

The look-ahead input passes through a flip-flop before it is combined with carry-in. An upstream slice must therefore drive it one clock before the carry-in.

The slice drives two carry flags, both taken straight from flip-flops so they cannot glitch:

- **Carry-out** (active low, with a true-polarity copy) is low after any counting edge that lands the count on the terminal value for the selected direction.
- **Look-ahead carry-out** (active low) is low after a counting edge that lands one step short of that terminal value.

Both flags are computed from the next-state value, not decoded from the count outputs.

Slices chain into a wide counter with no extra gating:

- The least significant slice has both carry inputs tied low.
- Its look-ahead output feeds the look-ahead input of every higher slice.
- Each higher slice takes its carry-in from the carry-out of the slice just below it.

The carry ripple then has a full wrap period of the low slice to settle. Feeding carry-out back to a mode bit makes a programmable divider. An asynchronous master reset clears the count and drives all three flag flip-flops high.

Top module: `regcarry_updown_ctr`

## Requirements
- R1: While master reset is high the count is 0 and both carry flags read high. The delayed look-ahead copy is also forced high, so the first clock after reset does not step the count even with both carry inputs low.
- R2: With mode 2'b00 the count takes the value on the data input at the clock edge, whatever the carry inputs are.
- R3: With mode 2'b01 the count steps up by one, wrapping from 2^W-1 to 0. It steps at an edge where carry-in is low and the look-ahead carry-in was low at the previous edge.
- R4: With mode 2'b10 the count steps down by one, wrapping from 0 to 2^W-1, under the same enable condition as R3.
- R5: In either counting mode the count holds if carry-in is high, or if look-ahead carry-in was high at the previous edge.
- R6: With mode 2'b11 the count, the carry-out and the look-ahead carry-out all keep their values. The look-ahead input is still sampled.
- R7: After an edge in a counting mode, carry-out is low exactly when the new count is the terminal value: 2^W-1 for mode 2'b01, 0 for mode 2'b10.
- R8: After an edge in a counting mode, look-ahead carry-out is low exactly when the new count is 2^W-2 for mode 2'b01, or 1 for mode 2'b10.
- R9: After a load edge both carry flags are high, even when the loaded value is a terminal value.
- R10: The true-polarity carry output is always the inverse of the active-low carry-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| mrst | input | 1 | Asynchronous master reset, active high |
| cin_n | input | 1 | Carry-in, active low |
| lin_n | input | 1 | Look-ahead carry-in, active low, registered inside |
| mode | input | 2 | 00 load, 01 up, 10 down, 11 hold |
| din | input | W | Parallel load value |
| q | output | W | Count |
| cout_n | output | 1 | Registered carry-out, active low |
| cout | output | 1 | Inverse of cout_n |
| lout_n | output | 1 | Registered look-ahead carry-out, active low |

## Verification
Up and down runs start from loads placed just short of each terminal value. Crossing the wrap in both directions separates a correct terminal compare from an off-by-one, and shows whether the flags track the selected direction. Stall patterns raise carry-in alone, and then raise look-ahead carry-in one edge earlier. This separates a correctly delayed look-ahead input from an undelayed one. Holding while carry-out is low, loading a terminal value, and a mid-run asynchronous reset show that the flags come from registers and keep or clear at the right moments.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [1:0] {
    MODE_LOAD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_HOLD = 2'b11
  } ctr_mode_e;
endpackage

// File: rtl/lookahead_reg.sv
module lookahead_reg (
  input  logic clk,
  input  logic mrst,
  input  logic lin_n,
  output logic lin_q
);
  // Sampled every clock in every mode; reset drives it high.
  always_ff @(posedge clk or posedge mrst) begin
    if (mrst) lin_q <= 1'b1;
    else      lin_q <= lin_n;
  end
endmodule

// File: rtl/count_core.sv
module count_core
  import ctr_pkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         mrst,
  input  ctr_mode_e    mode,
  input  logic         step_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    nxt = q;
    case (mode)
      MODE_LOAD: nxt = din;
      MODE_UP:   if (step_en) nxt = q + ONE;
      MODE_DOWN: if (step_en) nxt = q - ONE;
      default:   nxt = q;
    endcase
  end

  always_ff @(posedge clk or posedge mrst) begin
    if (mrst) q <= '0;
    else      q <= nxt;
  end
endmodule

// File: rtl/carry_flags.sv
module carry_flags
  import ctr_pkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         mrst,
  input  ctr_mode_e    mode,
  input  logic [W-1:0] nxt,
  output logic         cout_n,
  output logic         lout_n
);
  localparam logic [W-1:0] TC_UP  = '1;
  localparam logic [W-1:0] PRE_UP = TC_UP - {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] TC_DN  = '0;
  localparam logic [W-1:0] PRE_DN = {{(W-1){1'b0}}, 1'b1};

  logic cout_d, lout_d;

  // Flags are judged on the next-state value for the selected direction.
  always_comb begin
    cout_d = cout_n;
    lout_d = lout_n;
    case (mode)
      MODE_LOAD: begin cout_d = 1'b1;            lout_d = 1'b1;             end
      MODE_UP:   begin cout_d = (nxt != TC_UP);  lout_d = (nxt != PRE_UP);  end
      MODE_DOWN: begin cout_d = (nxt != TC_DN);  lout_d = (nxt != PRE_DN);  end
      default:   begin cout_d = cout_n;          lout_d = lout_n;           end
    endcase
  end

  always_ff @(posedge clk or posedge mrst) begin
    if (mrst) begin
      cout_n <= 1'b1;
      lout_n <= 1'b1;
    end else begin
      cout_n <= cout_d;
      lout_n <= lout_d;
    end
  end
endmodule

// File: rtl/regcarry_updown_ctr.sv
module regcarry_updown_ctr
  import ctr_pkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         mrst,
  input  logic         cin_n,
  input  logic         lin_n,
  input  logic [1:0]   mode,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         cout_n,
  output logic         cout,
  output logic         lout_n
);
  ctr_mode_e    mode_e;
  logic         lin_q;
  logic         step_en;
  logic [W-1:0] nxt;

  assign mode_e  = ctr_mode_e'(mode);
  assign step_en = ~cin_n & ~lin_q;

  lookahead_reg u_la (
    .clk   (clk),
    .mrst  (mrst),
    .lin_n (lin_n),
    .lin_q (lin_q)
  );

  count_core #(.W(W)) u_core (
    .clk     (clk),
    .mrst    (mrst),
    .mode    (mode_e),
    .step_en (step_en),
    .din     (din),
    .q       (q),
    .nxt     (nxt)
  );

  carry_flags #(.W(W)) u_flags (
    .clk    (clk),
    .mrst   (mrst),
    .mode   (mode_e),
    .nxt    (nxt),
    .cout_n (cout_n),
    .lout_n (lout_n)
  );

  assign cout = ~cout_n;
endmodule

// File: rtl/regcarry_updown_ctr_chk.sv
module regcarry_updown_ctr_chk #(
  parameter int W = 6
) (
  input logic         clk,
  input logic         mrst,
  input logic         cin_n,
  input logic         lin_q,
  input logic [1:0]   mode,
  input logic [W-1:0] din,
  input logic [W-1:0] q,
  input logic         cout_n,
  input logic         lout_n
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ALL1 = '1;
  localparam logic [W-1:0] PENU = ALL1 - ONE;

  a_r2_preset_loads: assert property (@(posedge clk) disable iff (mrst)
    (mode == 2'b00) |=> (q == $past(din)));

  a_r9_preset_flags_high: assert property (@(posedge clk) disable iff (mrst)
    (mode == 2'b00) |=> (cout_n && lout_n));

  a_r3_up_step: assert property (@(posedge clk) disable iff (mrst)
    (mode == 2'b01 && !cin_n && !lin_q) |=> (q == $past(q) + ONE));

  a_r4_down_step: assert property (@(posedge clk) disable iff (mrst)
    (mode == 2'b10 && !cin_n && !lin_q) |=> (q == $past(q) - ONE));

  a_r5_stall: assert property (@(posedge clk) disable iff (mrst)
    ((mode == 2'b01 || mode == 2'b10) && (cin_n || lin_q)) |=> $stable(q));

  a_r6_hold_all: assert property (@(posedge clk) disable iff (mrst)
    (mode == 2'b11) |=> ($stable(q) && $stable(cout_n) && $stable(lout_n)));

  a_r7_cout_up: assert property (@(posedge clk) disable iff (mrst)
    (mode == 2'b01) |=> (cout_n == (q != ALL1)));

  a_r7_cout_down: assert property (@(posedge clk) disable iff (mrst)
    (mode == 2'b10) |=> (cout_n == (q != '0)));

  a_r8_lout_up: assert property (@(posedge clk) disable iff (mrst)
    (mode == 2'b01) |=> (lout_n == (q != PENU)));

  a_r8_lout_down: assert property (@(posedge clk) disable iff (mrst)
    (mode == 2'b10) |=> (lout_n == (q != ONE)));
endmodule

bind regcarry_updown_ctr regcarry_updown_ctr_chk #(.W(W)) u_chk (
  .clk    (clk),
  .mrst   (mrst),
  .cin_n  (cin_n),
  .lin_q  (lin_q),
  .mode   (mode),
  .din    (din),
  .q      (q),
  .cout_n (cout_n),
  .lout_n (lout_n)
);

// File: tb/tb_regcarry_updown_ctr.sv
module tb_regcarry_updown_ctr;
  localparam int W = 6;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  logic mrst;
  logic cin_n, lin_n;
  logic [1:0] mode;
  logic [W-1:0] din;
  logic [W-1:0] q;
  logic cout_n, cout, lout_n;

  int checks = 0;
  int errors = 0;
  int m_q, m_co, m_lo, m_lq;

  always #4 clk = ~clk;

  regcarry_updown_ctr #(.W(W)) dut (
    .clk(clk), .mrst(mrst), .cin_n(cin_n), .lin_n(lin_n), .mode(mode),
    .din(din), .q(q), .cout_n(cout_n), .cout(cout), .lout_n(lout_n)
  );

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
    end
  endtask

  task automatic cmp_all(input string tag);
    chk(tag, "q", int'(q), m_q);
    chk(tag, "cout_n", int'(cout_n), m_co);
    chk(tag, "lout_n", int'(lout_n), m_lo);
    chk("R10", "cout", int'(cout), 1 - m_co);
  endtask

  task automatic model_reset();
    m_q = 0; m_co = 1; m_lo = 1; m_lq = 1;
  endtask

  task automatic step(input int md, input bit ci, input bit li, input int d, input string tag);
    bit en;
    mode = md[1:0]; cin_n = ci; lin_n = li; din = d[W-1:0];
    @(posedge clk);
    en = (ci == 1'b0) && (m_lq == 0);
    case (md)
      0: begin m_q = d % M; m_co = 1; m_lo = 1; end
      1: begin
        if (en) m_q = (m_q + 1) % M;
        m_co = (m_q == M - 1) ? 0 : 1;
        m_lo = (m_q == M - 2) ? 0 : 1;
      end
      2: begin
        if (en) m_q = (m_q + M - 1) % M;
        m_co = (m_q == 0) ? 0 : 1;
        m_lo = (m_q == 1) ? 0 : 1;
      end
      default: ;
    endcase
    m_lq = li;
    @(negedge clk);
    cmp_all(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mrst = 1'b1; cin_n = 1'b0; lin_n = 1'b0; mode = 2'b01; din = '0;
    model_reset();
    repeat (2) @(negedge clk);
    cmp_all("R1");                   // reset state
    mrst = 1'b0;
    step(1, 0, 0, 0, "R1");          // delayed look-ahead still high: no step
    step(1, 0, 0, 0, "R3");          // now counts
    // Up across the wrap
    step(0, 1, 0, 60, "R2");
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, "R3_R7_R8");
    // Down across the wrap
    step(0, 1, 1, 3, "R2");
    step(2, 0, 0, 0, "R5");          // look-ahead was high at prior edge
    for (int i = 0; i < 6; i++) step(2, 0, 0, 0, "R4_R7_R8");
    // Stall by carry-in
    step(2, 1, 0, 0, "R5");
    step(1, 1, 0, 0, "R5");
    // Stall by look-ahead one edge early
    step(1, 0, 1, 0, "R3");
    step(1, 0, 0, 0, "R5");
    step(1, 0, 0, 0, "R3");
    // Reach terminal, then hold with carry-out low
    step(0, 0, 0, 61, "R2");
    step(1, 0, 0, 0, "R8");
    step(1, 0, 0, 0, "R7");
    for (int i = 0; i < 3; i++) step(3, 0, i[0], 0, "R6");
    step(1, 1, 0, 0, "R7");          // parked at terminal, stays low
    // Loading terminal values keeps flags high
    step(0, 0, 0, M - 1, "R9");
    step(0, 0, 0, 0, "R9");
    step(0, 0, 0, M - 2, "R9");
    // Asynchronous reset in mid-cycle
    step(1, 0, 0, 0, "R7");
    #1 mrst = 1'b1;
    #1 model_reset();
    cmp_all("R1");
    @(negedge clk);
    mrst = 1'b0;
    step(1, 0, 0, 0, "R1");
    step(1, 0, 0, 0, "R3");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule